// File: doc/BRIEF.md
# Cascaded Multi-Channel DMA Address Generator

This block produces the transfer addresses and transfer counts for a legacy-compatible DMA engine. The engine has eight channel slots in two cascaded groups. Slots 0 to 3 move bytes. Slots 5 to 7 move 16-bit words. Slot 4 is the link between the two groups and never carries data. Every usable channel holds a base address, a base count, a current address, a current count, a page value, an auto-reload flag, a mask bit and a software request bit. All of these are written through one register write port.

A channel asks for service when it is unmasked and either its hardware request line or its software request bit is high. The lowest-numbered requesting channel is granted. While a grant stands, the block shows a 24-bit bus address, a width flag and a terminal-count flag for the pending transfer. Each transfer strobe completes one transfer on the granted channel: the current address moves up by one unit and the current count moves down by one.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset every channel is masked. No grant is given, even while all hardware request lines are high.
- R2: Register writes use `wr_kind` to pick the field. The codes are 0 base address, 1 base count, 2 page, 3 mode (bit 0 = auto-reload), 4 mask (bit 0, 1 = masked) and 5 software request (bit 0). Writing the base address or the base count also loads the matching current register.
- R3: On a byte channel (0 to 3), `bus_addr` is {page[7:0], current address[15:0]} and `xfer_word` is 0.
- R4: On a word channel (5 to 7), `bus_addr` is {page[7:1], current address[15:0], 1'b0} and `xfer_word` is 1. Page bit 0 is ignored.
- R5: Among the requesting channels, the lowest-numbered one is granted. Channel 4 is never granted, and writes addressed to channel 4 have no effect.
- R6: A channel requests service only when it is unmasked and its hardware line or its software request bit is set. The two request sources are treated the same way.
- R7: Each transfer strobe on a granted channel adds 1 to its current address and subtracts 1 from its current count. The address wraps within 16 bits and the page value does not change.
- R8: When a transfer strobe arrives while the current count is 0, `tc` is high for that transfer. If auto-reload is off, the channel's software request is then cleared and the channel becomes masked.
- R9: When a transfer strobe arrives while the current count is 0 and auto-reload is on, the current address and current count are reloaded from the base values. The software request is cleared and the channel stays unmasked.
- R10: If a register write to the granted channel lands in the same cycle as a transfer strobe, the stepping of the current address and current count takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Field selector for the write |
| wr_ch | input | 3 | Channel selected by the write |
| wr_data | input | 16 | Write data |
| hw_req | input | 8 | Hardware request line for each channel |
| xfer_stb | input | 1 | One transfer completed on the granted channel |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | 3 | Number of the granted channel |
| bus_addr | output | 24 | Bus address for the pending transfer |
| xfer_word | output | 1 | High when the pending transfer is 16 bits wide |
| tc | output | 1 | High when the pending transfer is the last one of the block |

## Verification
The assertions assume that `xfer_stb` arrives only while `grant_valid` is high. A strobe with no grant is dropped. They also assume that no mask write lands on a channel in the same cycle as its terminal-count step. The bench raises every strobe only after it has checked that a grant is present. It keeps mask writes and transfers in separate cycles, with one exception: the R10 case, which on purpose overlaps a base-address write with a strobe.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic [2:0] {
    K_BASE_ADDR = 3'd0,
    K_BASE_CNT  = 3'd1,
    K_PAGE      = 3'd2,
    K_MODE      = 3'd3,
    K_MASK      = 3'd4,
    K_SWREQ     = 3'd5
  } wr_kind_e;
endpackage

// File: rtl/dma_ag_chan.sv
module dma_ag_chan
  import dma_ag_pkg::*;
#(
  parameter int AW       = 16,
  parameter int PW       = 8,
  parameter int CW       = 16,
  parameter bit IS_WORD  = 1'b0,
  parameter bit RESERVED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [2:0]    wr_kind,
  input  logic [AW-1:0] wr_data,
  input  logic          hw_req,
  input  logic          step,
  output logic          req_act,
  output logic [PW+AW-1:0] addr_out,
  output logic          at_tc,
  output logic          auto_o,
  output logic          mask_o,
  output logic [AW-1:0] cur_addr_o
);
  logic [AW-1:0] base_a, cur_a;
  logic [CW-1:0] base_c, cur_c;
  logic [PW-1:0] page;
  logic          auto_q, mask_q, swr_q;
  logic          wr_ok;

  // byte: page above the address; word: address shifted up one place
  function automatic logic [PW+AW-1:0] form_addr(input logic [PW-1:0] pg,
                                                 input logic [AW-1:0] a);
    if (IS_WORD) form_addr = {pg[PW-1:1], a, 1'b0};
    else         form_addr = {pg, a};
  endfunction

  assign wr_ok      = wr_sel && !RESERVED;
  assign at_tc      = (cur_c == '0);
  assign req_act    = !RESERVED && !mask_q && (hw_req || swr_q);
  assign addr_out   = form_addr(page, cur_a);
  assign auto_o     = auto_q;
  assign mask_o     = mask_q;
  assign cur_addr_o = cur_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0; cur_a <= '0; base_c <= '0; cur_c <= '0;
      page <= '0; auto_q <= 1'b0; mask_q <= 1'b1; swr_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (wr_kind)
          K_BASE_ADDR: begin base_a <= wr_data; cur_a <= wr_data; end
          K_BASE_CNT:  begin base_c <= CW'(wr_data); cur_c <= CW'(wr_data); end
          K_PAGE:      page   <= wr_data[PW-1:0];
          K_MODE:      auto_q <= wr_data[0];
          K_MASK:      mask_q <= wr_data[0];
          K_SWREQ:     swr_q  <= wr_data[0];
          default: ;
        endcase
      end
      // stepping is placed after the write so it wins on a collision
      if (step) begin
        if (at_tc) begin
          swr_q <= 1'b0;
          if (auto_q) begin
            cur_a <= base_a;
            cur_c <= base_c;
          end else begin
            mask_q <= 1'b1;
            cur_a  <= cur_a + 1'b1;
            cur_c  <= cur_c - 1'b1;
          end
        end else begin
          cur_a <= cur_a + 1'b1;
          cur_c <= cur_c - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dma_ag_prio.sv
module dma_ag_prio #(
  parameter int NCH = 8,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt_vec,
  output logic [IW-1:0]  gnt_idx,
  output logic           any
);
  always_comb begin
    gnt_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) gnt_idx = i[IW-1:0];
    end
    any     = |req;
    gnt_vec = any ? (NCH'(1) << gnt_idx) : '0;
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int CASC_CH = 4,
  parameter int AW      = 16,
  parameter int PW      = 8,
  parameter int CW      = 16,
  localparam int IW     = $clog2(NCH),
  localparam int BW     = PW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_kind,
  input  logic [IW-1:0] wr_ch,
  input  logic [AW-1:0] wr_data,
  input  logic [NCH-1:0] hw_req,
  input  logic          xfer_stb,
  output logic          grant_valid,
  output logic [IW-1:0] grant_ch,
  output logic [BW-1:0] bus_addr,
  output logic          xfer_word,
  output logic          tc
);
  logic [NCH-1:0] req_vec, gnt_vec, tc_vec, auto_vec, mask_vec, step_vec;
  logic [BW-1:0]  addr_arr [NCH];
  logic [AW-1:0]  cura_arr [NCH];
  logic [AW-1:0]  cur_addr_sel;
  logic           step_fire, tc_fire;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_ag_chan #(
      .AW(AW), .PW(PW), .CW(CW),
      .IS_WORD(c > CASC_CH), .RESERVED(c == CASC_CH)
    ) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_en && (wr_ch == IW'(c))),
      .wr_kind   (wr_kind),
      .wr_data   (wr_data),
      .hw_req    (hw_req[c]),
      .step      (step_vec[c]),
      .req_act   (req_vec[c]),
      .addr_out  (addr_arr[c]),
      .at_tc     (tc_vec[c]),
      .auto_o    (auto_vec[c]),
      .mask_o    (mask_vec[c]),
      .cur_addr_o(cura_arr[c])
    );
  end

  dma_ag_prio #(.NCH(NCH)) prio_i (
    .req    (req_vec),
    .gnt_vec(gnt_vec),
    .gnt_idx(grant_ch),
    .any    (grant_valid)
  );

  assign step_vec     = gnt_vec & {NCH{xfer_stb}};
  assign step_fire    = xfer_stb && grant_valid;
  assign tc           = grant_valid && tc_vec[grant_ch];
  assign tc_fire      = step_fire && tc;
  assign bus_addr     = addr_arr[grant_ch];
  assign cur_addr_sel = cura_arr[grant_ch];
  assign xfer_word    = grant_valid && (grant_ch > IW'(CASC_CH));
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int NCH     = 8,
  parameter int CASC_CH = 4,
  parameter int AW      = 16,
  localparam int IW     = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          grant_valid,
  input logic [IW-1:0] grant_ch,
  input logic          bus_addr_lsb,
  input logic          xfer_word,
  input logic          tc,
  input logic          step_fire,
  input logic          tc_fire,
  input logic [NCH-1:0] gnt_vec,
  input logic [NCH-1:0] auto_vec,
  input logic [NCH-1:0] mask_vec,
  input logic [AW-1:0] cur_addr_sel
);
  a_r5_no_casc_grant: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> grant_ch != IW'(CASC_CH));

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_vec) && ((gnt_vec != '0) == grant_valid));

  a_r4_word_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ch > IW'(CASC_CH)) |-> (xfer_word && !bus_addr_lsb));

  a_r8_tc_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> grant_valid);

  a_r8_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_fire && !auto_vec[grant_ch]) |=> mask_vec[$past(grant_ch)]);

  a_r9_reload_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_fire && auto_vec[grant_ch]) |=> !mask_vec[$past(grant_ch)]);

  a_r7_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !tc) |=>
      (!(grant_valid && grant_ch == $past(grant_ch)) ||
       cur_addr_sel == AW'($past(cur_addr_sel) + 1'b1)));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.NCH(NCH), .CASC_CH(CASC_CH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .grant_valid(grant_valid), .grant_ch(grant_ch),
  .bus_addr_lsb(bus_addr[0]), .xfer_word(xfer_word), .tc(tc),
  .step_fire(step_fire), .tc_fire(tc_fire), .gnt_vec(gnt_vec),
  .auto_vec(auto_vec), .mask_vec(mask_vec), .cur_addr_sel(cur_addr_sel)
);

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, xfer_stb = 1'b0;
  logic [2:0] wr_kind = '0, wr_ch = '0;
  logic [15:0] wr_data = '0;
  logic [7:0] hw_req = '0;
  logic grant_valid, xfer_word, tc;
  logic [2:0] grant_ch;
  logic [23:0] bus_addr;

  int n_chk = 0, n_bad = 0;

  typedef struct { int ch; logic [23:0] a; logic w; logic t; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  dma_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_ch(wr_ch),
    .wr_data(wr_data), .hw_req(hw_req), .xfer_stb(xfer_stb),
    .grant_valid(grant_valid), .grant_ch(grant_ch), .bus_addr(bus_addr),
    .xfer_word(xfer_word), .tc(tc)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected bus address, restated arithmetically
  function automatic logic [23:0] exp_addr(input int ch, input logic [7:0] pg,
                                           input logic [15:0] a);
    if (ch > 4) return (24'(pg & 8'hFE) << 16) + (24'(a) * 2);
    return (24'(pg) << 16) + 24'(a);
  endfunction

  task automatic wr(input logic [2:0] k, input logic [2:0] ch, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_ch = ch; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push expected item, then strobe (optionally with a colliding write)
  task automatic xfer(input int ch, input logic [23:0] a, input logic w,
                      input logic t, input string tag, input bit collide = 1'b0,
                      input logic [15:0] cdata = '0);
    @(negedge clk);
    sb_q.push_back('{ch, a, w, t, tag});
    xfer_stb = 1'b1;
    if (collide) begin
      wr_en = 1'b1; wr_kind = 3'd0; wr_ch = 3'(ch); wr_data = cdata;
    end
    @(negedge clk);
    xfer_stb = 1'b0; wr_en = 1'b0;
  endtask

  // monitor: a quarter period after the driving edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (xfer_stb) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", 32'(grant_ch), 0);
      end else begin
        e = sb_q.pop_front();
        check(grant_valid && grant_ch == 3'(e.ch), {e.tag, " grant"}, 32'(grant_ch), 32'(e.ch));
        check(bus_addr == e.a, {e.tag, " addr"}, 32'(bus_addr), 32'(e.a));
        check(xfer_word == e.w && tc == e.t, {e.tag, " word/tc"},
              32'({xfer_word, tc}), 32'({e.w, e.t}));
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!grant_valid, "R1 reset no grant", 32'(grant_valid), 0);
    hw_req = 8'hFF;
    @(negedge clk); #1;
    check(!grant_valid, "R1 all masked", 32'(grant_valid), 0);

    // channel 4: unmask write must be ignored
    hw_req = 8'h10;
    wr(3'd4, 3'd4, 16'h0000);
    #1 check(!grant_valid, "R5 cascade slot never granted", 32'(grant_valid), 0);
    hw_req = 8'h00;

    // byte channel 2 via software request
    wr(3'd2, 3'd2, 16'h0012);
    wr(3'd0, 3'd2, 16'hFFFE);
    wr(3'd1, 3'd2, 16'h0002);
    wr(3'd4, 3'd2, 16'h0000);
    #1 check(!grant_valid, "R6 unmasked but no request", 32'(grant_valid), 0);
    wr(3'd5, 3'd2, 16'h0001);
    #1 check(grant_valid && grant_ch == 3'd2, "R6 software request grants", 32'(grant_ch), 2);
    check(bus_addr == exp_addr(2, 8'h12, 16'hFFFE) && !xfer_word, "R2 R3 byte address",
          32'(bus_addr), 32'(exp_addr(2, 8'h12, 16'hFFFE)));
    xfer(2, exp_addr(2, 8'h12, 16'hFFFE), 1'b0, 1'b0, "R3 step0");
    xfer(2, exp_addr(2, 8'h12, 16'hFFFF), 1'b0, 1'b0, "R7 step1");
    xfer(2, exp_addr(2, 8'h12, 16'h0000), 1'b0, 1'b1, "R7 wrap R8 tc");
    #1 check(!grant_valid, "R8 masked after tc", 32'(grant_valid), 0);

    // word channel 6, hardware request, auto-reload
    wr(3'd2, 3'd6, 16'h0035);
    wr(3'd0, 3'd6, 16'h1234);
    wr(3'd1, 3'd6, 16'h0001);
    wr(3'd3, 3'd6, 16'h0001);
    wr(3'd4, 3'd6, 16'h0000);
    hw_req = 8'h40;
    @(negedge clk); #1;
    check(grant_valid && grant_ch == 3'd6 && xfer_word &&
          bus_addr == 24'h342468, "R4 word address", 32'(bus_addr), 32'h342468);
    xfer(6, exp_addr(6, 8'h35, 16'h1234), 1'b1, 1'b0, "R4 step0");
    xfer(6, exp_addr(6, 8'h35, 16'h1235), 1'b1, 1'b1, "R4 R8 word tc");
    xfer(6, exp_addr(6, 8'h35, 16'h1234), 1'b1, 1'b0, "R9 reloaded");

    // priority: channel 1 over channel 6
    wr(3'd2, 3'd1, 16'h0001);
    wr(3'd0, 3'd1, 16'h0100);
    wr(3'd1, 3'd1, 16'h0005);
    wr(3'd4, 3'd1, 16'h0000);
    hw_req = 8'h42;
    @(negedge clk); #1;
    check(grant_ch == 3'd1 && bus_addr == 24'h010100, "R5 lowest wins",
          32'(grant_ch), 1);
    xfer(1, exp_addr(1, 8'h01, 16'h0100), 1'b0, 1'b0, "R5 step");
    xfer(1, exp_addr(1, 8'h01, 16'h0101), 1'b0, 1'b0, "R10 collide", 1'b1, 16'h7777);
    #1 check(bus_addr == 24'h010102, "R10 step wins over write", 32'(bus_addr), 32'h010102);
    wr(3'd0, 3'd1, 16'h0200);
    #1 check(bus_addr == 24'h010200, "R2 base write loads current", 32'(bus_addr), 32'h010200);
    hw_req = 8'h00;
    @(negedge clk); #1;
    check(sb_q.size() == 0, "scoreboard drained", 32'(sb_q.size()), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule